// File: doc/BRIEF.md
# Write-Protected Watchdog Timer

This block is a watchdog that sits on a microcontroller's special-function-register bus. A slow tick enable, nominally 32.768 kHz, advances a 16-bit counter. Software must keep re-arming the watchdog by writing its enable bit as 1 before a programmable number of ticks has passed. If it fails to do so, the block does one of two things. It either pulses a one-cycle system reset request, or it raises an interrupt request. That interrupt cannot be masked and stays asserted until it is acknowledged.

The single 8-bit control/status register is guarded against stray stores. A bit write that sets the unlock bit arms exactly one following bus write. If that write targets the register, it is applied, either as a whole byte or as a single bit. Any other store is dropped. The timeout is a power-of-two multiple of 512 ticks. One prescale code requests a reset at once, and the codes above it never time out. A status bit records every timeout. Only software or the hardware reset clears it, so it survives the reset the watchdog itself requests. A power-supply-monitor event input disarms the watchdog.

Top module: `wdt_guard`

## Requirements
- R1: After the hardware reset (`rst_n` low) the register reads 0x10, `rst_req` and `irq_req` are low, and the status bit is cleared. Register fields: bits 7:4 are the prescale code, bit 3 selects interrupt mode, bit 2 is the status bit, bit 1 is the enable bit and bit 0 is the unlock bit.
- R2: While the unlock bit is 0, a byte write, or a bit write to any bit other than bit 0, leaves the register unchanged.
- R3: A bit write of 1 to bit 0 at address `REG_ADDR` sets the unlock bit, which then reads 1. The next bus write, at any address, clears the unlock bit. If that write is at `REG_ADDR`, its byte value, or its single bit on a bit write, is applied to bits 7:1.
- R4: The counter advances only in cycles with `tick_en` high. For prescale codes 0 to 7, the timeout falls on the 2^(9+code)-th tick after the last restart.
- R5: With bit 3 at 0, a timeout drives `rst_req` high for exactly one cycle, in the cycle after the final tick, and clears bit 1 in the same cycle.
- R6: Every timeout sets bit 2. An accepted write of 0 to bit 2 clears it, and a write of 1 to it has no effect. A watchdog-requested reset leaves bit 2 set.
- R7: An accepted write that leaves bit 1 at 1 restarts the count from zero.
- R8: With bit 3 at 1, a timeout raises `irq_req`, which stays high until `irq_ack`. Bit 1 stays set, `rst_req` stays low, and the counter holds while the request is pending. It restarts from zero after the acknowledge.
- R9: Prescale code 8 (bits 7:4 = 1000) with bit 1 set gives a one-cycle `rst_req` in the cycle after the write. The same cycle sets bit 2 and clears bit 1.
- R10: Prescale codes 9 to 15 never time out while enabled.
- R11: A high `psm_clr` clears bit 1, which stops the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low hardware reset |
| tick_en | input | 1 | One-cycle tick enable at the watchdog rate |
| wr_en | input | 1 | Bus write strobe |
| wr_bit | input | 1 | 1 = single-bit write, 0 = byte write |
| wr_addr | input | 8 | Bus write address |
| wr_bitsel | input | 3 | Bit index for a bit write |
| wr_data | input | 8 | Byte data; bit 0 carries the value of a bit write |
| psm_clr | input | 1 | Power-supply-monitor event, disarms the watchdog |
| irq_ack | input | 1 | Clears a pending interrupt request |
| ctrl_out | output | 8 | Register contents |
| rst_req | output | 1 | One-cycle system reset request |
| irq_req | output | 1 | Held watchdog interrupt request |

## Verification
Register updates show on `ctrl_out` one clock after the write edge, so the unlock bit, applied values and dropped stores are read at the following falling edge. A timeout comes one edge after the tick that completes the count. With the tick held high, `rst_req` or `irq_req` is low after 2^(9+code)-1 edges from the restarting write and high after the next edge, and the bench samples exactly those two falling edges and the one after. Prescale code 8 gives its pulse one edge after the write. An acknowledge restarts the full interval from the edge after it, and the bench checks both sides of that boundary.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

    // Register image, bit 7 down to bit 0
    typedef struct packed {
        logic [3:0] pre;       // prescale code
        logic       irq_mode;  // 1 = interrupt on timeout, 0 = reset
        logic       stat;      // timeout has occurred
        logic       en;        // watchdog armed
        logic       unlock;    // next bus write may modify the register
    } ctrl_t;

    localparam logic [7:0] CTRL_RESET  = 8'h10;
    localparam logic [3:0] PRE_IMM     = 4'd8;
    localparam logic [3:0] PRE_LAST_RUN = 4'd7;

    typedef struct packed {
        logic rst;
        logic irq;
    } evt_t;

endpackage

// File: rtl/wdt_guard_ctrl.sv
module wdt_guard_ctrl
    import wdt_guard_pkg::*;
#(
    parameter logic [7:0] REG_ADDR = 8'hC0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_bit,
    input  logic [7:0] wr_addr,
    input  logic [2:0] wr_bitsel,
    input  logic [7:0] wr_data,
    input  logic       psm_clr,
    input  logic       expire,
    input  logic       imm_fire,
    output ctrl_t      ctrl,
    output logic       refresh
);

    ctrl_t ctrl_d, ctrl_q;
    logic  hit;
    logic  accept;
    logic  arm;
    logic [7:0] cand;

    always_comb begin
        ctrl_d  = ctrl_q;
        hit     = wr_en && (wr_addr == REG_ADDR);
        accept  = hit && ctrl_q.unlock;
        arm     = hit && !ctrl_q.unlock && wr_bit &&
                  (wr_bitsel == 3'd0) && wr_data[0];
        refresh = 1'b0;

        // candidate value: whole byte, or current image with one bit replaced
        cand = ctrl_q;
        if (wr_bit) begin
            cand[wr_bitsel] = wr_data[0];
        end else begin
            cand = wr_data;
        end

        if (wr_en && ctrl_q.unlock) begin
            ctrl_d.unlock = 1'b0;
        end

        if (accept) begin
            ctrl_d.pre      = cand[7:4];
            ctrl_d.irq_mode = cand[3];
            if (!cand[2]) begin
                ctrl_d.stat = 1'b0;
            end
            ctrl_d.en = cand[1];
            refresh   = cand[1];
        end else if (arm) begin
            ctrl_d.unlock = 1'b1;
        end

        // hardware events override software in the same cycle
        if (expire || imm_fire) begin
            ctrl_d.stat = 1'b1;
        end
        if ((expire && !ctrl_q.irq_mode) || imm_fire || psm_clr) begin
            ctrl_d.en = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= ctrl_t'(CTRL_RESET);
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl = ctrl_q;

endmodule

// File: rtl/wdt_guard_count.sv
module wdt_guard_count
    import wdt_guard_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int BASE_LOG = 9,
    parameter int NUM_RUN  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       en,
    input  logic [3:0] pre,
    input  logic       refresh,
    input  logic       hold,
    output logic       expire,
    output logic       imm_fire
);

    localparam int SEL_W = $clog2(NUM_RUN);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [CNT_W-1:0] lim_tab [NUM_RUN];
    logic [CNT_W-1:0] lim;
    logic             runnable;
    logic             step;

    // terminal count for each running prescale code
    for (genvar g = 0; g < NUM_RUN; g++) begin : g_lim
        localparam longint unsigned SPAN = longint'(1) << (BASE_LOG + g);
        assign lim_tab[g] = CNT_W'(SPAN - 1);
    end

    always_comb begin
        st_d     = st_q;
        runnable = (pre <= PRE_LAST_RUN);
        lim      = lim_tab[pre[SEL_W-1:0]];
        step     = en && tick_en && !hold && runnable && !refresh;
        expire   = step && (st_q.cnt == lim);
        imm_fire = en && (pre == PRE_IMM);

        if (refresh || !en) begin
            st_d.cnt = '0;
        end else if (expire) begin
            st_d.cnt = '0;
        end else if (step) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/wdt_guard_evt.sv
module wdt_guard_evt
    import wdt_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic imm_fire,
    input  logic irq_mode,
    input  logic irq_ack,
    output logic rst_req,
    output logic irq_req
);

    evt_t evt_d, evt_q;

    always_comb begin
        evt_d     = evt_q;
        evt_d.rst = (expire && !irq_mode) || imm_fire;
        if (expire && irq_mode) begin
            evt_d.irq = 1'b1;
        end else if (irq_ack) begin
            evt_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q <= '0;
        end else begin
            evt_q <= evt_d;
        end
    end

    assign rst_req = evt_q.rst;
    assign irq_req = evt_q.irq;

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
    import wdt_guard_pkg::*;
#(
    parameter logic [7:0] REG_ADDR = 8'hC0,
    parameter int         CNT_W    = 16,
    parameter int         BASE_LOG = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       wr_en,
    input  logic       wr_bit,
    input  logic [7:0] wr_addr,
    input  logic [2:0] wr_bitsel,
    input  logic [7:0] wr_data,
    input  logic       psm_clr,
    input  logic       irq_ack,
    output logic [7:0] ctrl_out,
    output logic       rst_req,
    output logic       irq_req
);

    localparam int NUM_RUN = int'(PRE_LAST_RUN) + 1;

    ctrl_t ctrl;
    logic  refresh;
    logic  expire;
    logic  imm_fire;

    wdt_guard_ctrl #(
        .REG_ADDR (REG_ADDR)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_bit    (wr_bit),
        .wr_addr   (wr_addr),
        .wr_bitsel (wr_bitsel),
        .wr_data   (wr_data),
        .psm_clr   (psm_clr),
        .expire    (expire),
        .imm_fire  (imm_fire),
        .ctrl      (ctrl),
        .refresh   (refresh)
    );

    wdt_guard_count #(
        .CNT_W    (CNT_W),
        .BASE_LOG (BASE_LOG),
        .NUM_RUN  (NUM_RUN)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .en       (ctrl.en),
        .pre      (ctrl.pre),
        .refresh  (refresh),
        .hold     (irq_req),
        .expire   (expire),
        .imm_fire (imm_fire)
    );

    wdt_guard_evt u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire   (expire),
        .imm_fire (imm_fire),
        .irq_mode (ctrl.irq_mode),
        .irq_ack  (irq_ack),
        .rst_req  (rst_req),
        .irq_req  (irq_req)
    );

    assign ctrl_out = ctrl;

endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       wr_bit,
    input logic       irq_ack,
    input logic [7:0] ctrl_out,
    input logic       rst_req,
    input logic       irq_req
);

    // R5: reset request lasts one cycle
    a_r5_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R5: enable bit is clear while the reset request is high
    a_r5_rst_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !ctrl_out[1]);

    // R6: status bit is set alongside the reset request
    a_r6_stat_on_rst: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> ctrl_out[2]);

    // R6: status bit is set when the interrupt request rises
    a_r6_stat_on_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> ctrl_out[2]);

    // R8: interrupt request holds until acknowledged
    a_r8_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack) |=> irq_req);

    // R2: locked byte writes do not change prescale or mode
    a_r2_locked_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_bit && !ctrl_out[0]) |=> $stable(ctrl_out[7:3]));

    // R3: the unlock bit is consumed by the next write
    a_r3_unlock_once: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ctrl_out[0]) |=> !ctrl_out[0]);

endmodule

bind wdt_guard wdt_guard_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_bit   (wr_bit),
    .irq_ack  (irq_ack),
    .ctrl_out (ctrl_out),
    .rst_req  (rst_req),
    .irq_req  (irq_req)
);

// File: tb/tb_wdt_guard.sv
module tb_wdt_guard;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] ADDR = 8'hC0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_bit = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [2:0] wr_bitsel = '0;
    logic [7:0] wr_data = '0;
    logic       psm_clr = 1'b0;
    logic       irq_ack = 1'b0;
    logic [7:0] ctrl_out;
    logic       rst_req;
    logic       irq_req;

    int total = 0;
    int bad = 0;
    int rst_seen = 0;
    bit done = 1'b0;

    wdt_guard dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_bit(wr_bit), .wr_addr(wr_addr), .wr_bitsel(wr_bitsel),
        .wr_data(wr_data), .psm_clr(psm_clr), .irq_ack(irq_ack),
        .ctrl_out(ctrl_out), .rst_req(rst_req), .irq_req(irq_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) if (rst_req) rst_seen++;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_byte(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_bit = 1'b0; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_bit(input logic [7:0] a, input logic [2:0] s, input logic v);
        wr_en = 1'b1; wr_bit = 1'b1; wr_addr = a; wr_bitsel = s; wr_data = {7'd0, v};
        @(negedge clk);
        wr_en = 1'b0; wr_bit = 1'b0;
    endtask

    task automatic prot_write(input logic [7:0] d);
        bus_bit(ADDR, 3'd0, 1'b1);
        bus_byte(ADDR, d);
    endtask

    task automatic t_reset;
        check("R1 reset value", ctrl_out, 8'h10);
        check("R1 rst_req low", rst_req, 0);
        check("R1 irq_req low", irq_req, 0);
    endtask

    task automatic t_locked;
        bus_byte(ADDR, 8'h72);
        check("R2 locked byte write", ctrl_out, 8'h10);
        bus_bit(ADDR, 3'd1, 1'b1);
        check("R2 locked bit write", ctrl_out, 8'h10);
    endtask

    task automatic t_unlock;
        bus_bit(ADDR, 3'd0, 1'b1);
        check("R3 unlock bit reads 1", ctrl_out, 8'h11);
        bus_byte(ADDR, 8'h00);
        check("R3 byte write applied", ctrl_out, 8'h00);
        bus_bit(ADDR, 3'd0, 1'b1);
        bus_byte(8'h80, 8'hFF);
        check("R3 other address consumes unlock", ctrl_out, 8'h00);
        bus_byte(ADDR, 8'h72);
        check("R3 write after consumed unlock dropped", ctrl_out, 8'h00);
        bus_bit(ADDR, 3'd0, 1'b1);
        bus_bit(ADDR, 3'd3, 1'b1);
        check("R3 bit write applied", ctrl_out, 8'h08);
        prot_write(8'h00);
        check("R3 cleared again", ctrl_out, 8'h00);
    endtask

    task automatic t_rst_timeout;
        int base;
        base = rst_seen;
        tick_en = 1'b1;
        prot_write(8'h02);
        step(511);
        check("R4 no reset before 512 ticks", rst_req, 0);
        step(1);
        check("R5 reset at 512th tick", rst_req, 1);
        check("R5 R6 stat set, enable cleared", ctrl_out, 8'h04);
        step(1);
        check("R5 reset pulse one cycle", rst_req, 0);
        check("R5 exactly one pulse", rst_seen - base, 1);
    endtask

    task automatic t_stat;
        prot_write(8'h04);
        check("R6 writing 1 to status keeps it", ctrl_out, 8'h04);
        prot_write(8'h00);
        check("R6 writing 0 clears status", ctrl_out, 8'h00);
    endtask

    task automatic t_refresh;
        int base;
        base = rst_seen;
        prot_write(8'h12);
        step(1000);
        prot_write(8'h12);
        check("R7 no reset while refreshed", rst_seen - base, 0);
        step(1023);
        check("R7 count restarted by refresh", rst_req, 0);
        step(1);
        check("R4 code 1 expires at 1024 ticks", rst_req, 1);
        step(1);
        prot_write(8'h00);
    endtask

    task automatic t_irq;
        int base;
        base = rst_seen;
        prot_write(8'h0A);
        step(511);
        check("R8 no interrupt early", irq_req, 0);
        step(1);
        check("R8 interrupt raised", irq_req, 1);
        step(600);
        check("R8 interrupt held", irq_req, 1);
        check("R8 enable kept, status set", ctrl_out, 8'h0E);
        check("R8 no reset in interrupt mode", rst_seen - base, 0);
        irq_ack = 1'b1;
        step(1);
        irq_ack = 1'b0;
        check("R8 acknowledge clears request", irq_req, 0);
        step(511);
        check("R8 counter held while pending", irq_req, 0);
        step(1);
        check("R8 restart after acknowledge", irq_req, 1);
        irq_ack = 1'b1;
        step(1);
        irq_ack = 1'b0;
        prot_write(8'h00);
    endtask

    task automatic t_imm;
        prot_write(8'h82);
        check("R9 no pulse in write cycle", rst_req, 0);
        step(1);
        check("R9 immediate reset", rst_req, 1);
        check("R9 status set, enable cleared", ctrl_out, 8'h84);
        step(1);
        check("R9 single pulse", rst_req, 0);
        prot_write(8'h00);
    endtask

    task automatic t_reserved;
        int base;
        base = rst_seen;
        prot_write(8'h92);
        step(3000);
        check("R10 reserved code never resets", rst_seen - base, 0);
        check("R10 reserved code never interrupts", irq_req, 0);
        check("R10 register unchanged", ctrl_out, 8'h92);
        prot_write(8'h00);
    endtask

    task automatic t_psm;
        int base;
        base = rst_seen;
        prot_write(8'h02);
        psm_clr = 1'b1;
        step(1);
        psm_clr = 1'b0;
        check("R11 monitor event clears enable", ctrl_out, 8'h00);
        step(1000);
        check("R11 no timeout after disarm", rst_seen - base, 0);
    endtask

    task automatic t_tick_gate;
        int base;
        base = rst_seen;
        tick_en = 1'b0;
        prot_write(8'h02);
        step(2000);
        check("R4 no count without ticks", rst_seen - base, 0);
        tick_en = 1'b1;
        step(511);
        check("R4 511 ticks not enough", rst_req, 0);
        step(1);
        check("R4 512 ticks expire", rst_req, 1);
        step(1);
    endtask

    task automatic t_hw_reset;
        check("R6 status survives watchdog reset", ctrl_out, 8'h04);
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
        check("R1 hardware reset clears status", ctrl_out, 8'h10);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL all watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_locked();
        t_unlock();
        t_rst_timeout();
        t_stat();
        t_refresh();
        t_irq();
        t_imm();
        t_reserved();
        t_psm();
        t_tick_gate();
        t_hw_reset();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule